// File: doc/BRIEF.md
# Processor Reset Stretcher with Bus-Request Strap

This block turns an active-low platform reset into an active-low processor reset that stays asserted for a programmable number of clocks after the platform reset releases. The delay is a parameter sized from the clock frequency: 100,000 cycles gives roughly 1 ms at 100 MHz. The platform reset asserts everything at once and without a clock. Its release passes through a two-flop synchronizer before the stretch counter starts.

Alongside the processor reset, the block drives an active-low bus-request strap. The strap stays low for the whole of the processor reset, so the processor has a guaranteed setup window before it samples the strap on the reset's rising edge. The strap then stays low for a fixed hold of 2 to 20 clocks after the reset rises, and then goes high. If the platform reset asserts again at any point, the whole sequence starts over.

Top module: `cpu_reset_seq`

## Requirements
- R1: While rst_ni is low, cpu_rst_no is low, including before any clock edge after rst_ni falls.
- R2: While rst_ni is low, strap_no is low, including before any clock edge after rst_ni falls.
- R3: cpu_rst_no goes high right after the (STRETCH_CYCLES+2)-th rising clock edge counted from rst_ni going high. Two of these edges are synchronizer latency.
- R4: strap_no is low in every cycle in which cpu_rst_no is low.
- R5: strap_no goes high right after the STRAP_HOLD-th rising edge counted from the edge that released cpu_rst_no, so it stays low for exactly STRAP_HOLD clocks after reset release.
- R6: The strap is low for at least 4 clocks before cpu_rst_no rises. Elaboration rejects STRETCH_CYCLES below 2.
- R7: Elaboration rejects STRAP_HOLD outside 2..20. Both ends of this range work as R5 describes.
- R8: If rst_ni asserts during the stretch or during the strap hold, both outputs drop at once, and the full sequence in R3 and R5 runs again after the next release.
- R9: Once cpu_rst_no or strap_no has gone high, it stays high until rst_ni asserts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Platform reset, active low, asynchronous |
| cpu_rst_no | output | 1 | Processor reset, active low |
| strap_no | output | 1 | Bus-request strap, active low, driven low through reset and hold |

## Verification
Each output has a fixed edge count after rst_ni rises. cpu_rst_no is due after edge STRETCH_CYCLES+2, and strap_no is due STRAP_HOLD edges after that. The bench counts rising edges since the last release in an integer and samples both outputs on every falling edge. This puts each sample half a cycle after the edge that changes the output.

Reset assertion has no clock latency. The bench therefore drives rst_ni low between edges and samples a nanosecond later, before any edge can arrive. Three instances cover the default hold, the minimum stretch with the minimum hold, and the maximum hold.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned MIN_HOLD    = 2;
  localparam int unsigned MAX_HOLD    = 20;
  localparam int unsigned MIN_STRETCH = 2;

  typedef enum logic [1:0] {
    PH_RESET   = 2'd0,
    PH_STRETCH = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  typedef enum logic {
    STRAP_DRIVE = 1'b0,
    STRAP_FREE  = 1'b1
  } strap_st_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sync_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= 1'b1;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign sync_no = chain_q[STAGES-1];

  // R1
  sync_low_in_rst_chk: assert property (@(posedge clk_i) !rst_ni |-> !sync_no);
endmodule

// File: rtl/stretch_timer.sv
module stretch_timer #(
  parameter int unsigned STRETCH_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  output logic release_o
);
  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (sync_ni && !rel_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) rel_q <= 1'b1;
    end
  end

  assign release_o = rel_q;

  // R3
  rel_needs_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(sync_ni));
  // R9
  rel_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |=> rel_q);
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned STRAP_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_rel_i,
  output logic strap_no
);
  localparam int unsigned HW = $clog2(STRAP_HOLD + 1);
  localparam logic [HW-1:0] LAST = HW'(STRAP_HOLD - 1);

  strap_st_e     st_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= STRAP_DRIVE;
      hold_q <= '0;
    end else if (st_q == STRAP_DRIVE && cpu_rel_i) begin
      hold_q <= hold_q + 1'b1;
      if (hold_q == LAST) st_q <= STRAP_FREE;
    end
  end

  assign strap_no = (st_q == STRAP_FREE);

  // R4
  strap_low_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rel_i |-> !strap_no);
  // R9
  strap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_no |=> strap_no);
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 100000,
  parameter int unsigned STRAP_HOLD     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cpu_rst_no,
  output logic strap_no
);
  // R7
  generate
    if (STRAP_HOLD < MIN_HOLD || STRAP_HOLD > MAX_HOLD) begin : g_bad_hold
      $error("STRAP_HOLD must lie in 2..20");
    end
    // R6
    if (STRETCH_CYCLES < MIN_STRETCH) begin : g_bad_stretch
      $error("STRETCH_CYCLES must be at least 2");
    end
  endgenerate

  logic sync_n;
  logic rel;
  logic strap_n;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_no(sync_n)
  );

  stretch_timer #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_ni  (sync_n),
    .release_o(rel)
  );

  strap_ctrl #(.STRAP_HOLD(STRAP_HOLD)) u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_rel_i(rel),
    .strap_no (strap_n)
  );

  assign cpu_rst_no = rel;
  assign strap_no   = strap_n;

  phase_e phase;
  always_comb begin
    if (!sync_n)       phase = PH_RESET;
    else if (!rel)     phase = PH_STRETCH;
    else if (!strap_n) phase = PH_HOLD;
    else               phase = PH_RUN;
  end

  // Observation counters for timing checks, saturating.
  localparam int unsigned OBS_MAX = STRETCH_CYCLES + STRAP_HOLD + 4;
  int unsigned sync_cnt_q, hold_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_cnt_q <= 0;
      hold_cnt_q <= 0;
    end else begin
      if (sync_n && sync_cnt_q < OBS_MAX) sync_cnt_q <= sync_cnt_q + 1;
      if (rel && hold_cnt_q < OBS_MAX)    hold_cnt_q <= hold_cnt_q + 1;
    end
  end

  // R3
  stretch_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> sync_cnt_q == STRETCH_CYCLES);
  // R3
  no_early_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |-> sync_cnt_q >= STRETCH_CYCLES);
  // R5
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strap_no) |-> hold_cnt_q == STRAP_HOLD);
  // R5
  hold_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_HOLD) |-> hold_cnt_q < STRAP_HOLD);
  // R2
  strap_async_chk: assert property (@(posedge clk_i) !rst_ni |-> (!strap_no && !cpu_rst_no));
endmodule

// File: tb/cpu_reset_seq_test.sv
`timescale 1ns/1ps
module cpu_reset_seq_test;
  localparam int S_A = 12, H_A = 4;
  localparam int S_B = 2,  H_B = 2;
  localparam int S_C = 7,  H_C = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_a, strap_a, cpu_b, strap_b, cpu_c, strap_c;

  cpu_reset_seq #(.STRETCH_CYCLES(S_A), .STRAP_HOLD(H_A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rst_no(cpu_a), .strap_no(strap_a));
  cpu_reset_seq #(.STRETCH_CYCLES(S_B), .STRAP_HOLD(H_B)) uut_min (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rst_no(cpu_b), .strap_no(strap_b));
  cpu_reset_seq #(.STRETCH_CYCLES(S_C), .STRAP_HOLD(H_C)) uut_max (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rst_no(cpu_c), .strap_no(strap_c));

  int checks = 0, fails = 0, edges = 0, cycles = 0;
  int low_run_b = 0;
  bit run_model = 1'b0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, edges, act, exp);
    end
  endtask

  // Behavioural model: outputs purely from edges since release.
  task automatic compare_all();
    chk("R3", "uut cpu",   cpu_a,   logic'(edges >= S_A + 2));
    chk("R5", "uut strap", strap_a, logic'(edges >= S_A + 2 + H_A));
    chk("R6", "min cpu",   cpu_b,   logic'(edges >= S_B + 2));
    chk("R7", "min strap", strap_b, logic'(edges >= S_B + 2 + H_B));
    chk("R3", "max cpu",   cpu_c,   logic'(edges >= S_C + 2));
    chk("R7", "max strap", strap_c, logic'(edges >= S_C + 2 + H_C));
    // R4
    if (!cpu_a) chk("R4", "strap in reset", strap_a, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) edges++;
  end

  always @(negedge clk) begin
    if (run_model) begin
      compare_all();
      // R6: strap low at least 4 samples before cpu release on the minimum instance
      if (!strap_b && !cpu_b) low_run_b++;
      if (cpu_b && low_run_b != 0) begin
        chk("R6", "setup before release", logic'(low_run_b >= 4), 1'b1);
        low_run_b = 0;
      end
    end
  end

  task automatic assert_reset();
    @(negedge clk); #2;
    rst_n = 1'b0;
    edges = 0;
    #1;
    // R1, R2, R8: immediate drop, before any clock edge
    chk("R1", "async cpu",   cpu_a,   1'b0);
    chk("R2", "async strap", strap_a, 1'b0);
    chk("R8", "async cpu max", cpu_c, 1'b0);
    chk("R2", "async strap max", strap_c, 1'b0);
  endtask

  task automatic release_reset();
    @(negedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #1;
    chk("R1", "reset cpu",   cpu_a,   1'b0);
    chk("R2", "reset strap", strap_a, 1'b0);
    run_model = 1'b1;
    wait_cycles(5);
    // R3, R5, R9: full sequence
    release_reset();
    wait_cycles(S_C + H_C + 10);
    // R8: reassert during stretch
    assert_reset();
    wait_cycles(3);
    release_reset();
    wait_cycles(6);
    assert_reset();
    wait_cycles(2);
    release_reset();
    wait_cycles(S_C + H_C + 10);
    // R8: reassert during strap hold of uut
    assert_reset();
    release_reset();
    wait_cycles(S_A + 2 + 2);
    assert_reset();
    wait_cycles(4);
    release_reset();
    // R9: long run, outputs stay high
    wait_cycles(S_C + H_C + 40);
    finish_test();
  end

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles >= 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_test();
  end
endmodule